// File: doc/BRIEF.md
# Programmable Reference Clock Divider

This block sits between a reference clock input and a phase-frequency detector. It turns the reference into a clock-enable pulse train with a programmable integer ratio. A bypass control gives divide-by-one, which asserts the enable on every reference cycle. With bypass low, a 3-bit ratio code selects a division ratio from 2 to 7. The effective ratio R used for frequency planning is therefore always between 1 and 7.

Ratio and bypass changes never cut a period short. The block samples its controls only at the clock edge that produces an output pulse, and those settings govern the whole following interval. This prevents runt pulses at the detector input. Ratio codes 000 and 001 have no meaning while the divider is enabled. For these codes the block raises a flag and falls back to divide-by-2.

The whole block runs on the reference clock. It uses a synchronous active-high reset, and both outputs are registered.

Top module: `ref_clk_divider`

## Requirements
- R1: While `rst` is high at a clock edge, both `tick_o` and `bad_code_o` are 0 after that edge, and the internal cycle count returns to zero.
- R2: After reset is released, the first `tick_o` pulse is seen after the R-th rising edge with `rst` low. R is taken from the controls present at the last reset edge.
- R3: With `bypass_i` high, R is 1 and `tick_o` is high on every cycle. The value of `ratio_code_i` has no effect on `tick_o` in this case.
- R4: With `bypass_i` low, a code value n in the range 2 to 7 gives R = n. The code is read as an unsigned 3-bit number with bit 2 as the most significant bit (010 = 2, 111 = 7).
- R5: For R of 2 or more, `tick_o` is a single-cycle pulse, and consecutive pulses are exactly R cycles apart.
- R6: With `bypass_i` low, codes 000 and 001 give R = 2.
- R7: `bad_code_o` is 1 in the cycle after an edge at which `bypass_i` was low and the code was 000 or 001. It is 0 after any other edge, including bypass with code 000.
- R8: The controls present at the edge that raises `tick_o` set the length of the next interval. Changes made in the middle of an interval do not alter that interval.
- R9: Once the first pulse after reset has appeared, no interval between pulses exceeds 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass_i | input | 1 | High selects divide-by-one |
| ratio_code_i | input | 3 | Ratio code; value 2..7 is the ratio when bypass is low |
| tick_o | output | 1 | Registered divided clock-enable pulse |
| bad_code_o | output | 1 | Registered flag for code 000 or 001 with bypass low |

## Verification
On every cycle, the bound checker confirms several things. Each measured interval between pulses must equal the ratio implied by the controls at the launching edge. No interval may exceed the maximum ratio. The illegal-code flag must follow the control inputs with one cycle of delay, and reset must clear both outputs.

Some behaviours can only be shown by the bench's scenarios. These are the position of the first pulse after reset and the mapping of every legal code. They also include the divide-by-2 fallback and the proof that mid-interval control changes leave the current period intact. The bench shows them through a cycle-by-cycle reference model fed through a scoreboard queue.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS   = 2'd0,
    MODE_DIVIDE   = 2'd1,
    MODE_FALLBACK = 2'd2
  } div_mode_e;

endpackage

// File: rtl/ref_div_decode.sv
module ref_div_decode
  import ref_div_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int MIN_RATIO = 2,
  parameter int CNT_W     = 3
) (
  input  logic              bypass_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  ratio_o,
  output div_mode_e         mode_o
);

  localparam logic [CODE_W-1:0] MIN_CODE = CODE_W'(MIN_RATIO);

  always_comb begin
    if (bypass_i) begin
      mode_o  = MODE_BYPASS;
      ratio_o = CNT_W'(1);
    end else if (code_i < MIN_CODE) begin
      mode_o  = MODE_FALLBACK;
      ratio_o = CNT_W'(MIN_RATIO);
    end else begin
      mode_o  = MODE_DIVIDE;
      ratio_o = CNT_W'(code_i);
    end
  end

endmodule

// File: rtl/ref_div_counter.sv
module ref_div_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] next_ratio_i,
  output logic             wrap_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] active_q;

  assign wrap_o = (count_q == active_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      active_q <= next_ratio_i;
    end else if (wrap_o) begin
      count_q  <= '0;
      active_q <= next_ratio_i;
    end else begin
      count_q  <= count_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ref_clk_divider.sv
module ref_clk_divider
  import ref_div_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int MIN_RATIO = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_i,
  input  logic [CODE_W-1:0] ratio_code_i,
  output logic              tick_o,
  output logic              bad_code_o
);

  localparam int MAX_RATIO = (1 << CODE_W) - 1;
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  logic [CNT_W-1:0] next_ratio;
  div_mode_e        next_mode;
  logic             wrap;

  ref_div_decode #(
    .CODE_W   (CODE_W),
    .MIN_RATIO(MIN_RATIO),
    .CNT_W    (CNT_W)
  ) u_decode (
    .bypass_i(bypass_i),
    .code_i  (ratio_code_i),
    .ratio_o (next_ratio),
    .mode_o  (next_mode)
  );

  ref_div_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk         (clk),
    .rst         (rst),
    .next_ratio_i(next_ratio),
    .wrap_o      (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_o     <= 1'b0;
      bad_code_o <= 1'b0;
    end else begin
      tick_o     <= wrap;
      bad_code_o <= (next_mode == MODE_FALLBACK);
    end
  end

endmodule

// File: rtl/ref_div_checker.sv
module ref_div_checker #(
  parameter int CODE_W    = 3,
  parameter int MIN_RATIO = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bypass_i,
  input logic [CODE_W-1:0] ratio_code_i,
  input logic              tick_o,
  input logic              bad_code_o
);

  localparam int MAX_RATIO = (1 << CODE_W) - 1;

  logic              prev_byp;
  logic [CODE_W-1:0] prev_code;
  logic              armed;
  int unsigned       since;
  int unsigned       exp_gap;

  always_ff @(posedge clk) begin
    prev_byp  <= bypass_i;
    prev_code <= ratio_code_i;
    if (rst) begin
      armed   <= 1'b0;
      since   <= 0;
      exp_gap <= 0;
    end else if (tick_o) begin
      armed   <= 1'b1;
      since   <= 1;
      exp_gap <= prev_byp ? 1 :
                 ((int'(prev_code) < MIN_RATIO) ? MIN_RATIO : int'(prev_code));
    end else if (since < 1000) begin
      since <= since + 1;
    end
  end

  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!tick_o && !bad_code_o));

  // R8 (also covers R3, R4, R5, R6 interval lengths)
  p_interval_r8: assert property (@(posedge clk) disable iff (rst)
    (tick_o && armed) |-> (since == exp_gap));

  // R9
  p_max_gap_r9: assert property (@(posedge clk) disable iff (rst)
    armed |-> (since <= MAX_RATIO));

  // R7
  p_bad_set_r7: assert property (@(posedge clk) disable iff (rst)
    (!bypass_i && (int'(ratio_code_i) < MIN_RATIO)) |=> bad_code_o);

  // R7
  p_bad_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (bypass_i || (int'(ratio_code_i) >= MIN_RATIO)) |=> !bad_code_o);

endmodule

bind ref_clk_divider ref_div_checker #(
  .CODE_W   (CODE_W),
  .MIN_RATIO(MIN_RATIO)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bypass_i    (bypass_i),
  .ratio_code_i(ratio_code_i),
  .tick_o      (tick_o),
  .bad_code_o  (bad_code_o)
);

// File: tb/test_ref_clk_divider.sv
module test_ref_clk_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bypass_i = 1'b0;
  logic [2:0] ratio_code_i = 3'd3;
  logic       tick_o;
  logic       bad_code_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string phase = "R1";

  logic [1:0] exp_q[$];

  int m_cnt = 0;
  int m_act = 1;

  always #10 clk = ~clk;

  ref_clk_divider i_ref_clk_divider (
    .clk         (clk),
    .rst         (rst),
    .bypass_i    (bypass_i),
    .ratio_code_i(ratio_code_i),
    .tick_o      (tick_o),
    .bad_code_o  (bad_code_o)
  );

  function automatic int req_ratio(logic byp, logic [2:0] code);
    if (byp) return 1;
    if (code < 3'd2) return 2;
    return int'(code);
  endfunction

  // Reference model: produces expected outputs after each rising edge
  always @(posedge clk) begin
    logic e_tick;
    logic e_bad;
    if (rst) begin
      m_cnt = 0;
      m_act = req_ratio(bypass_i, ratio_code_i);
      e_tick = 1'b0;
      e_bad  = 1'b0;
    end else begin
      e_bad = !bypass_i && (ratio_code_i < 3'd2);
      if (m_cnt == m_act - 1) begin
        e_tick = 1'b1;
        m_cnt  = 0;
        m_act  = req_ratio(bypass_i, ratio_code_i);
      end else begin
        e_tick = 1'b0;
        m_cnt  = m_cnt + 1;
      end
    end
    exp_q.push_back({e_tick, e_bad});
  end

  // Monitor: compares at falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      e = exp_q.pop_front();
      compared++;
      if ({tick_o, bad_code_o} !== e) begin
        mismatched++;
        $display("FAIL %s: tick/bad actual %b%b expected %b%b at %0t",
                 phase, tick_o, bad_code_o, e[1], e[0], $time);
      end
    end
  end

  task automatic drive(input logic byp, input logic [2:0] code, input int cycles);
    @(negedge clk);
    bypass_i     = byp;
    ratio_code_i = code;
    for (int i = 1; i < cycles; i++) @(negedge clk);
  endtask

  initial begin
    #200_000_000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    rst = 1'b1;
    bypass_i = 1'b0;
    ratio_code_i = 3'd3;
    repeat (4) @(negedge clk);
    phase = "R2";
    rst = 1'b0;
    repeat (4) @(negedge clk);
    phase = "R5";
    repeat (12) @(negedge clk);
    phase = "R4";
    for (int c = 2; c <= 7; c++) drive(1'b0, 3'(c), 22);
    phase = "R3";
    for (int c = 0; c < 8; c++) drive(1'b1, 3'(c), 3);
    phase = "R6 R7";
    drive(1'b0, 3'd0, 12);
    drive(1'b0, 3'd1, 12);
    drive(1'b1, 3'd0, 5);
    phase = "R8";
    for (int k = 0; k < 20; k++) drive(1'b0, (k % 2) ? 3'd2 : 3'd7, 3);
    for (int k = 0; k < 10; k++) drive(k[0], 3'd5, 2);
    phase = "R9";
    drive(1'b0, 3'd7, 40);
    phase = "R1";
    @(negedge clk);
    rst = 1'b1;
    ratio_code_i = 3'd6;
    repeat (3) @(negedge clk);
    phase = "R2";
    rst = 1'b0;
    repeat (14) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule